// File: doc/BRIEF.md
# Scoreboarded Register File with Condition Flags

This block is the architectural register storage of a small pipelined 32-bit processor. It keeps sixteen 32-bit registers. Each register has its own valid bit, which works as a scoreboard. When decode issues an instruction whose result will arrive later, it marks the destination as pending through an invalidate port. The valid bit comes back when the result is written through one of the two write-back ports. Decode reads operands on three combinational ports, and each port returns the data and the valid bit of its register.

A condition-flag register holds carry, zero, negative and overflow. Carry, zero and negative share one valid bit; overflow has its own. A flag write-back loads all four flags and sets both valid bits, and each group can be invalidated on its own. Register 15 is the program counter. It is visible on dedicated outputs and advances by one word on an increment command. A write-back that targets register 15 in the same cycle takes precedence over the increment.

Top module: `scoreboard_regfile`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) clears all registers and all four flags to zero. It sets every register valid bit, both flag valid bits and pc_valid to 1.
- R2: Each of the three read ports (port k uses rd_addr[4k+3:4k], rd_data[32k+31:32k] and rd_valid[k]) returns the contents and the valid bit of its addressed register combinationally. A write in the same cycle shows on the port only after the next rising edge.
- R3: A write on port A or port B stores its data into the addressed register at the next rising edge and sets that register's valid bit.
- R4: When both write ports target the same register in one cycle, the register takes the port A data.
- R5: An asserted invalidate on either invalidate port clears the valid bit of its addressed register at the next rising edge. Registers that are not addressed keep their valid bits.
- R6: When an invalidate and a write target the same register in one cycle, the data is stored but the valid bit ends up cleared.
- R7: flg_we loads flag_out = {c,z,n,v} from {flg_c_in,flg_z_in,flg_n_in,flg_v_in} at the next edge and sets both flag valid bits. flag_valid is {czn_valid, v_valid}.
- R8: kill_czn clears only the carry/zero/negative valid bit, and kill_v clears only the overflow valid bit. Each wins over a flag write in the same cycle.
- R9: Without flg_we, the four flag values keep their previous values.
- R10: pc_value and pc_valid are the contents and valid bit of register 15. pc_inc adds 4 to it at the next edge and leaves its valid bit unchanged.
- R11: A write to register 15 on either write port overrides a pc_inc in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_a_en | input | 1 | Priority write port enable |
| wr_a_addr | input | 4 | Priority write port register index |
| wr_a_data | input | 32 | Priority write port data |
| wr_b_en | input | 1 | Secondary write port enable |
| wr_b_addr | input | 4 | Secondary write port register index |
| wr_b_data | input | 32 | Secondary write port data |
| kill_a_en | input | 1 | First invalidate enable |
| kill_a_addr | input | 4 | First invalidate register index |
| kill_b_en | input | 1 | Second invalidate enable |
| kill_b_addr | input | 4 | Second invalidate register index |
| rd_addr | input | 12 | Three packed read addresses, port 0 in the low bits |
| rd_data | output | 96 | Three packed read data words, port 0 in the low bits |
| rd_valid | output | 3 | Valid bit per read port |
| flg_we | input | 1 | Flag write-back enable |
| flg_c_in | input | 1 | Carry to write |
| flg_z_in | input | 1 | Zero to write |
| flg_n_in | input | 1 | Negative to write |
| flg_v_in | input | 1 | Overflow to write |
| kill_czn | input | 1 | Invalidate carry/zero/negative group |
| kill_v | input | 1 | Invalidate overflow |
| flag_out | output | 4 | Current flags {c,z,n,v} |
| flag_valid | output | 2 | {czn valid, v valid} |
| pc_inc | input | 1 | Advance program counter by 4 |
| pc_value | output | 32 | Program counter (register 15) |
| pc_valid | output | 1 | Program counter valid bit |

## Verification
Register, valid-bit and flag updates are due one rising edge after the stimulus is held. Read-port results are due in the same cycle once the address settles. The bench drives inputs between edges and waits for the edge. It then moves the read addresses, lets them settle and only then has its monitor compare the queued expectations. A separate check, made before the edge with a write pending, confirms that the read port still shows the old data.

// File: rtl/rf_pkg.sv
package rf_pkg;

    localparam int RF_NREGS   = 16;
    localparam int RF_DW      = 32;
    localparam int RF_NRD     = 3;
    localparam int RF_PC_STEP = 4;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
    } flags_t;

    typedef struct packed {
        flags_t f;
        logic   czn_ok;
        logic   v_ok;
    } flag_state_t;

endpackage

// File: rtl/rf_onehot.sv
module rf_onehot #(
    parameter int N  = 16,
    parameter int AW = $clog2(N)
) (
    input  logic          en,
    input  logic [AW-1:0] addr,
    output logic [N-1:0]  hit
);

    for (genvar g = 0; g < N; g++) begin : g_dec
        assign hit[g] = en && (addr == AW'(g));
    end

endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    parameter int PC_STEP  = 4,
    parameter int ADDR_W   = $clog2(NUM_REGS),
    parameter int PC_IDX   = NUM_REGS - 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_REGS-1:0]              wa_hit,
    input  logic [DATA_W-1:0]                wa_data,
    input  logic [NUM_REGS-1:0]              wb_hit,
    input  logic [DATA_W-1:0]                wb_data,
    input  logic [NUM_REGS-1:0]              kill_hit,
    input  logic                             pc_inc,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o,
    output logic [NUM_REGS-1:0]              vld_o
);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
        logic [NUM_REGS-1:0]             vld;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            // lowest precedence: program counter step
            if (i == PC_IDX && pc_inc)
                st_d.regs[i] = st_q.regs[i] + DATA_W'(PC_STEP);
            // secondary write, then priority write overriding it
            if (wb_hit[i])
                st_d.regs[i] = wb_data;
            if (wa_hit[i])
                st_d.regs[i] = wa_data;
            // scoreboard: write-back marks ready, newer producer marks pending
            if (wa_hit[i] || wb_hit[i])
                st_d.vld[i] = 1'b1;
            if (kill_hit[i])
                st_d.vld[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.regs <= '0;
            st_q.vld  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_o = st_q.regs;
    assign vld_o  = st_q.vld;

endmodule

// File: rtl/rf_flags.sv
module rf_flags
    import rf_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   we,
    input  flags_t wdata,
    input  logic   kill_czn,
    input  logic   kill_v,
    output flags_t flags_o,
    output logic   czn_ok_o,
    output logic   v_ok_o
);

    flag_state_t fs_d, fs_q;

    always_comb begin
        fs_d = fs_q;
        if (we) begin
            fs_d.f      = wdata;
            fs_d.czn_ok = 1'b1;
            fs_d.v_ok   = 1'b1;
        end
        if (kill_czn)
            fs_d.czn_ok = 1'b0;
        if (kill_v)
            fs_d.v_ok = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q.f      <= '0;
            fs_q.czn_ok <= 1'b1;
            fs_q.v_ok   <= 1'b1;
        end else begin
            fs_q <= fs_d;
        end
    end

    assign flags_o  = fs_q.f;
    assign czn_ok_o = fs_q.czn_ok;
    assign v_ok_o   = fs_q.v_ok;

endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
    input  logic [NUM_REGS-1:0]             vld_i,
    input  logic [ADDR_W-1:0]               addr,
    output logic [DATA_W-1:0]               data,
    output logic                            valid
);

    assign data  = regs_i[addr];
    assign valid = vld_i[addr];

endmodule

// File: rtl/scoreboard_regfile.sv
module scoreboard_regfile
    import rf_pkg::*;
#(
    parameter int NUM_REGS = RF_NREGS,
    parameter int DATA_W   = RF_DW,
    parameter int NUM_RD   = RF_NRD,
    parameter int PC_STEP  = RF_PC_STEP,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_a_en,
    input  logic [ADDR_W-1:0]          wr_a_addr,
    input  logic [DATA_W-1:0]          wr_a_data,
    input  logic                       wr_b_en,
    input  logic [ADDR_W-1:0]          wr_b_addr,
    input  logic [DATA_W-1:0]          wr_b_data,
    input  logic                       kill_a_en,
    input  logic [ADDR_W-1:0]          kill_a_addr,
    input  logic                       kill_b_en,
    input  logic [ADDR_W-1:0]          kill_b_addr,
    input  logic [NUM_RD*ADDR_W-1:0]   rd_addr,
    output logic [NUM_RD*DATA_W-1:0]   rd_data,
    output logic [NUM_RD-1:0]          rd_valid,
    input  logic                       flg_we,
    input  logic                       flg_c_in,
    input  logic                       flg_z_in,
    input  logic                       flg_n_in,
    input  logic                       flg_v_in,
    input  logic                       kill_czn,
    input  logic                       kill_v,
    output logic [3:0]                 flag_out,
    output logic [1:0]                 flag_valid,
    input  logic                       pc_inc,
    output logic [DATA_W-1:0]          pc_value,
    output logic                       pc_valid
);

    localparam int PC_IDX = NUM_REGS - 1;

    logic [NUM_REGS-1:0]             wa_hit, wb_hit, ka_hit, kb_hit;
    logic [NUM_REGS-1:0][DATA_W-1:0] bank_regs;
    logic [NUM_REGS-1:0]             bank_vld;
    flags_t                          flg_q;
    flags_t                          flg_wdata;
    logic                            czn_ok, v_ok;

    rf_onehot #(.N(NUM_REGS), .AW(ADDR_W)) i_dec_wa (
        .en(wr_a_en), .addr(wr_a_addr), .hit(wa_hit));
    rf_onehot #(.N(NUM_REGS), .AW(ADDR_W)) i_dec_wb (
        .en(wr_b_en), .addr(wr_b_addr), .hit(wb_hit));
    rf_onehot #(.N(NUM_REGS), .AW(ADDR_W)) i_dec_ka (
        .en(kill_a_en), .addr(kill_a_addr), .hit(ka_hit));
    rf_onehot #(.N(NUM_REGS), .AW(ADDR_W)) i_dec_kb (
        .en(kill_b_en), .addr(kill_b_addr), .hit(kb_hit));

    rf_bank #(
        .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .PC_STEP(PC_STEP),
        .ADDR_W(ADDR_W), .PC_IDX(PC_IDX)
    ) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wa_hit   (wa_hit),
        .wa_data  (wr_a_data),
        .wb_hit   (wb_hit),
        .wb_data  (wr_b_data),
        .kill_hit (ka_hit | kb_hit),
        .pc_inc   (pc_inc),
        .regs_o   (bank_regs),
        .vld_o    (bank_vld)
    );

    for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
        rf_read_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_rd (
            .regs_i (bank_regs),
            .vld_i  (bank_vld),
            .addr   (rd_addr[g*ADDR_W +: ADDR_W]),
            .data   (rd_data[g*DATA_W +: DATA_W]),
            .valid  (rd_valid[g])
        );
    end

    assign flg_wdata = '{c: flg_c_in, z: flg_z_in, n: flg_n_in, v: flg_v_in};

    rf_flags i_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (flg_we),
        .wdata    (flg_wdata),
        .kill_czn (kill_czn),
        .kill_v   (kill_v),
        .flags_o  (flg_q),
        .czn_ok_o (czn_ok),
        .v_ok_o   (v_ok)
    );

    assign flag_out   = {flg_q.c, flg_q.z, flg_q.n, flg_q.v};
    assign flag_valid = {czn_ok, v_ok};
    assign pc_value   = bank_regs[PC_IDX];
    assign pc_valid   = bank_vld[PC_IDX];

endmodule

// File: rtl/rf_chk.sv
module rf_chk #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    parameter int PC_STEP  = 4,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             wr_a_en,
    input logic [ADDR_W-1:0]                wr_a_addr,
    input logic [DATA_W-1:0]                wr_a_data,
    input logic                             wr_b_en,
    input logic [ADDR_W-1:0]                wr_b_addr,
    input logic [DATA_W-1:0]                wr_b_data,
    input logic                             kill_a_en,
    input logic [ADDR_W-1:0]                kill_a_addr,
    input logic                             kill_b_en,
    input logic [ADDR_W-1:0]                kill_b_addr,
    input logic                             flg_we,
    input logic                             flg_c_in,
    input logic                             flg_z_in,
    input logic                             flg_n_in,
    input logic                             flg_v_in,
    input logic                             kill_czn,
    input logic                             kill_v,
    input logic [3:0]                       flag_out,
    input logic [1:0]                       flag_valid,
    input logic                             pc_inc,
    input logic [DATA_W-1:0]                pc_value,
    input logic [NUM_REGS-1:0][DATA_W-1:0]  bank_regs,
    input logic [NUM_REGS-1:0]              bank_vld
);

    localparam logic [ADDR_W-1:0] PC_A = ADDR_W'(NUM_REGS - 1);

    // R3
    wr_a_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_a_en && !(kill_a_en && kill_a_addr == wr_a_addr)
                && !(kill_b_en && kill_b_addr == wr_a_addr)
        |=> bank_regs[$past(wr_a_addr)] == $past(wr_a_data) && bank_vld[$past(wr_a_addr)]);

    // R4
    wr_a_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_a_en && wr_b_en && wr_a_addr == wr_b_addr
        |=> bank_regs[$past(wr_a_addr)] == $past(wr_a_data));

    // R6
    kill_a_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_a_en |=> !bank_vld[$past(kill_a_addr)]);

    // R5
    kill_b_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_b_en |=> !bank_vld[$past(kill_b_addr)]);

    // R7
    flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flg_we |=> flag_out == $past({flg_c_in, flg_z_in, flg_n_in, flg_v_in}));

    // R8
    czn_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_czn |=> !flag_valid[1]);

    // R8
    v_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_v |=> !flag_valid[0]);

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flg_we |=> $stable(flag_out));

    // R10
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inc && !(wr_a_en && wr_a_addr == PC_A) && !(wr_b_en && wr_b_addr == PC_A)
        |=> pc_value == $past(pc_value) + DATA_W'(PC_STEP));

    // R11
    pc_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_b_en && wr_b_addr == PC_A && !(wr_a_en && wr_a_addr == PC_A)
        |=> pc_value == $past(wr_b_data));

endmodule

bind scoreboard_regfile rf_chk #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .PC_STEP(PC_STEP), .ADDR_W(ADDR_W)
) i_rf_chk (
    .clk(clk), .rst_n(rst_n),
    .wr_a_en(wr_a_en), .wr_a_addr(wr_a_addr), .wr_a_data(wr_a_data),
    .wr_b_en(wr_b_en), .wr_b_addr(wr_b_addr), .wr_b_data(wr_b_data),
    .kill_a_en(kill_a_en), .kill_a_addr(kill_a_addr),
    .kill_b_en(kill_b_en), .kill_b_addr(kill_b_addr),
    .flg_we(flg_we), .flg_c_in(flg_c_in), .flg_z_in(flg_z_in),
    .flg_n_in(flg_n_in), .flg_v_in(flg_v_in),
    .kill_czn(kill_czn), .kill_v(kill_v),
    .flag_out(flag_out), .flag_valid(flag_valid),
    .pc_inc(pc_inc), .pc_value(pc_value),
    .bank_regs(bank_regs), .bank_vld(bank_vld)
);

// File: tb/test_scoreboard_regfile.sv
`timescale 1ns/100ps
module test_scoreboard_regfile;

    localparam int DW  = 32;
    localparam int AW  = 4;
    localparam int NRD = 3;

    localparam int K_RDATA = 0;
    localparam int K_RVLD  = 1;
    localparam int K_PC    = 2;
    localparam int K_PCV   = 3;
    localparam int K_FLAGS = 4;
    localparam int K_FLGV  = 5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic               rst_n;
    logic               wr_a_en, wr_b_en, kill_a_en, kill_b_en;
    logic [AW-1:0]      wr_a_addr, wr_b_addr, kill_a_addr, kill_b_addr;
    logic [DW-1:0]      wr_a_data, wr_b_data;
    logic [NRD*AW-1:0]  rd_addr;
    logic [NRD*DW-1:0]  rd_data;
    logic [NRD-1:0]     rd_valid;
    logic               flg_we, flg_c_in, flg_z_in, flg_n_in, flg_v_in;
    logic               kill_czn, kill_v, pc_inc, pc_valid;
    logic [3:0]         flag_out;
    logic [1:0]         flag_valid;
    logic [DW-1:0]      pc_value;

    scoreboard_regfile i_scoreboard_regfile (
        .clk(clk), .rst_n(rst_n),
        .wr_a_en(wr_a_en), .wr_a_addr(wr_a_addr), .wr_a_data(wr_a_data),
        .wr_b_en(wr_b_en), .wr_b_addr(wr_b_addr), .wr_b_data(wr_b_data),
        .kill_a_en(kill_a_en), .kill_a_addr(kill_a_addr),
        .kill_b_en(kill_b_en), .kill_b_addr(kill_b_addr),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .flg_we(flg_we), .flg_c_in(flg_c_in), .flg_z_in(flg_z_in),
        .flg_n_in(flg_n_in), .flg_v_in(flg_v_in),
        .kill_czn(kill_czn), .kill_v(kill_v),
        .flag_out(flag_out), .flag_valid(flag_valid),
        .pc_inc(pc_inc), .pc_value(pc_value), .pc_valid(pc_valid)
    );

    typedef struct {
        int          kind;
        int          idx;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    event  sample_ev;
    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;

    function automatic logic [31:0] observe(int kind, int idx);
        case (kind)
            K_RDATA: return rd_data[idx*DW +: DW];
            K_RVLD:  return {31'd0, rd_valid[idx]};
            K_PC:    return pc_value;
            K_PCV:   return {31'd0, pc_valid};
            K_FLAGS: return {28'd0, flag_out};
            default: return {30'd0, flag_valid};
        endcase
    endfunction

    // monitor: pops expectations and compares at each sample point
    initial begin
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = q.pop_front();
                act = observe(it.kind, it.idx);
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                             it.tag, it.kind, it.idx, act, it.exp);
                end
            end
        end
    end

    task automatic expect_item(int kind, int idx, logic [31:0] v, string tag);
        item_t it;
        it.kind = kind; it.idx = idx; it.exp = v; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle_inputs();
        wr_a_en = 0; wr_b_en = 0; kill_a_en = 0; kill_b_en = 0;
        wr_a_addr = '0; wr_b_addr = '0; kill_a_addr = '0; kill_b_addr = '0;
        wr_a_data = '0; wr_b_data = '0;
        flg_we = 0; flg_c_in = 0; flg_z_in = 0; flg_n_in = 0; flg_v_in = 0;
        kill_czn = 0; kill_v = 0; pc_inc = 0;
    endtask

    task automatic set_rd(int p, int a);
        rd_addr[p*AW +: AW] = AW'(a);
    endtask

    // inputs held so far are taken at the next rising edge
    task automatic tick();
        @(posedge clk);
        #1;
        idle_inputs();
    endtask

    // let read addresses settle, then release the monitor
    task automatic sample();
        #0.5;
        -> sample_ev;
        #0.5;
    endtask

    initial begin
        rst_n = 0;
        rd_addr = '0;
        idle_inputs();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;

        // R1 reset state
        set_rd(0, 0); set_rd(1, 5); set_rd(2, 15);
        expect_item(K_RDATA, 0, 32'h0, "R1 reg0 data");
        expect_item(K_RVLD,  1, 32'h1, "R1 reg5 valid");
        expect_item(K_RDATA, 2, 32'h0, "R1 reg15 data");
        expect_item(K_PC,    0, 32'h0, "R1 pc");
        expect_item(K_PCV,   0, 32'h1, "R1 pc valid");
        expect_item(K_FLAGS, 0, 32'h0, "R1 flags");
        expect_item(K_FLGV,  0, 32'h3, "R1 flag valids");
        sample();

        // R2 read shows old data while a write is pending
        wr_a_en = 1; wr_a_addr = 3; wr_a_data = 32'h1111_2222;
        wr_b_en = 1; wr_b_addr = 7; wr_b_data = 32'hA5A5_A5A5;
        set_rd(0, 3);
        expect_item(K_RDATA, 0, 32'h0, "R2 no same-cycle bypass");
        sample();
        tick();
        // R3 both ports land; R2 three ports independent
        set_rd(0, 3); set_rd(1, 7); set_rd(2, 3);
        expect_item(K_RDATA, 0, 32'h1111_2222, "R3 port A write");
        expect_item(K_RDATA, 1, 32'hA5A5_A5A5, "R3 port B write");
        expect_item(K_RVLD,  2, 32'h1, "R2 port2 valid");
        sample();

        // R4 same address on both write ports
        wr_a_en = 1; wr_a_addr = 9; wr_a_data = 32'hAAAA_0001;
        wr_b_en = 1; wr_b_addr = 9; wr_b_data = 32'hBBBB_0002;
        tick();
        set_rd(1, 9);
        expect_item(K_RDATA, 1, 32'hAAAA_0001, "R4 port A priority");
        sample();

        // R5 invalidate on both ports
        kill_a_en = 1; kill_a_addr = 3;
        kill_b_en = 1; kill_b_addr = 7;
        tick();
        set_rd(0, 3); set_rd(1, 7); set_rd(2, 9);
        expect_item(K_RVLD, 0, 32'h0, "R5 kill port A");
        expect_item(K_RVLD, 1, 32'h0, "R5 kill port B");
        expect_item(K_RVLD, 2, 32'h1, "R5 other register untouched");
        sample();

        // R6 invalidate beats write on the same register
        wr_a_en = 1; wr_a_addr = 3; wr_a_data = 32'h0000_0033;
        kill_a_en = 1; kill_a_addr = 3;
        wr_b_en = 1; wr_b_addr = 7; wr_b_data = 32'h0000_0077;
        tick();
        expect_item(K_RVLD,  0, 32'h0, "R6 kill wins over write");
        expect_item(K_RDATA, 0, 32'h0000_0033, "R6 data still stored");
        expect_item(K_RVLD,  1, 32'h1, "R3 port B write restores valid");
        sample();
        wr_a_en = 1; wr_a_addr = 3; wr_a_data = 32'h0000_0044;
        tick();
        expect_item(K_RVLD,  0, 32'h1, "R3 write restores valid");
        expect_item(K_RDATA, 0, 32'h0000_0044, "R3 rewrite data");
        sample();

        // R7 flag write
        flg_we = 1; flg_c_in = 1; flg_z_in = 0; flg_n_in = 1; flg_v_in = 1;
        tick();
        expect_item(K_FLAGS, 0, 32'hB, "R7 flags loaded");
        expect_item(K_FLGV,  0, 32'h3, "R7 flag valids set");
        sample();

        // R8 czn kill alone; R9 values hold
        kill_czn = 1;
        tick();
        expect_item(K_FLGV,  0, 32'h1, "R8 czn kill only");
        expect_item(K_FLAGS, 0, 32'hB, "R9 flags hold");
        sample();

        // R8 overflow kill beats flag write; R7 czn valid set again
        flg_we = 1; flg_c_in = 0; flg_z_in = 1; flg_n_in = 0; flg_v_in = 0;
        kill_v = 1;
        tick();
        expect_item(K_FLAGS, 0, 32'h4, "R7 flags loaded with kill");
        expect_item(K_FLGV,  0, 32'h2, "R8 v kill wins");
        sample();

        // R9 idle cycle
        tick();
        expect_item(K_FLAGS, 0, 32'h4, "R9 idle hold");
        sample();

        // R10 program counter increment
        pc_inc = 1;
        tick();
        expect_item(K_PC, 0, 32'h4, "R10 pc +4");
        sample();
        pc_inc = 1;
        tick();
        set_rd(2, 15);
        expect_item(K_PC,    0, 32'h8, "R10 pc +8");
        expect_item(K_RDATA, 2, 32'h8, "R10 pc is register 15");
        sample();

        // R11 write-back overrides increment
        pc_inc = 1; wr_b_en = 1; wr_b_addr = 15; wr_b_data = 32'h0000_0100;
        tick();
        expect_item(K_PC, 0, 32'h0000_0100, "R11 port B over increment");
        sample();
        pc_inc = 1; wr_a_en = 1; wr_a_addr = 15; wr_a_data = 32'h0000_0200;
        tick();
        expect_item(K_PC, 0, 32'h0000_0200, "R11 port A over increment");
        sample();

        // R10 pc validity follows register 15, unchanged by increment
        kill_b_en = 1; kill_b_addr = 15;
        tick();
        expect_item(K_PCV, 0, 32'h0, "R10 pc invalidated");
        sample();
        pc_inc = 1;
        tick();
        expect_item(K_PC,  0, 32'h0000_0204, "R10 pc step while pending");
        expect_item(K_PCV, 0, 32'h0, "R10 increment keeps valid bit");
        sample();

        // R1 reset again after activity
        rst_n = 0;
        tick();
        rst_n = 1;
        set_rd(0, 3);
        expect_item(K_RDATA, 0, 32'h0, "R1 reset clears data");
        expect_item(K_PCV,   0, 32'h1, "R1 reset pc valid");
        expect_item(K_FLGV,  0, 32'h3, "R1 reset flag valids");
        sample();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule